// File: doc/BRIEF.md
# Burst-of-Two Double-Data-Rate Separate-I/O SRAM Model

This block is a synthesizable behavioural model of a synchronous SRAM with separate read and write ports. The two ports share one address bus. A read takes its address on the rising edge of the input clock. A write takes its address on the rising edge of the complement input clock, half a period later. Each location holds a pair of words, and every access moves exactly that pair. The lower-order word always comes first, and the two words travel on the two clock phases of a single input-clock period.

Writes carry a per-word, per-9-bit-lane write enable. Reads are pipelined and come out on a pair of output clocks, so a board can deskew the returning data. If both output clocks are held high during reset, the model uses the input clocks for the output timing instead, and keeps that choice until the next reset. Tri-state output pins are replaced by a valid flag: it is high while a word of a read burst is on the output bus, and the bus reads zero when the flag is low. A small array of parameterized depth stands in for the full memory.

Top module: `b2s_sram`

## Requirements
- R1: A read starts when `rd_sel_n` is low at a rising edge of `clk_in`, and the address is taken at that same edge. The lower word is presented from the `clk_out_n` rise that follows the next `clk_in` rise. The upper word is presented from the following `clk_out` rise.
- R2: A write starts when `wr_sel_n` is low at a rising edge of `clk_in`, and the lower word and its lane enables are taken at that edge. The write address, the upper word and the upper lane enables are taken at the next rising edge of `clk_in_n`.
- R3: Each address holds two DATA_W-bit words. A read returns both words of the addressed location, lower word first, within one `clk_in` period.
- R4: `lane_we_n[i]` is active low and covers data bits 9*i+8 down to 9*i. It is sampled separately for the lower word and the upper word. A lane whose enable is high keeps its stored value in that word.
- R5: A read returns the data of every write that started at the same `clk_in` rise as the read or earlier. This includes a partial-lane write that is still in flight.
- R6: `rdata_vld` is high exactly while a word of a read burst is presented, and `rdata` is zero whenever `rdata_vld` is low. When no read follows, the drive is released at the next output clock rise after the upper word.
- R7: A write or read that has already started completes even when its port select goes high on the very next `clk_in` rise.
- R8: If `clk_out` and `clk_out_n` are both high while `rst_n` is low at a `clk_in` rise, the outputs are timed by `clk_in` and `clk_in_n` instead. This choice stays fixed until the next reset, whatever the output clocks do afterwards.
- R9: A read and a write may start at the same `clk_in` rise to different addresses. Neither disturbs the other.
- R10: While `rst_n` is low (synchronous, active low), no read or write is pending. After reset, `rdata_vld` is low and `rdata` is zero.
- R11: With `wr_sel_n` high, the address, write data and lane enables change no stored data. With `rd_sel_n` high, no burst is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | True input clock; commands, read address and lower write word are taken on its rising edge |
| clk_in_n | input | 1 | Complement input clock; write address and upper write word are taken on its rising edge |
| clk_out | input | 1 | True output clock; the upper read word is presented from its rising edge |
| clk_out_n | input | 1 | Complement output clock; the lower read word is presented from its rising edge |
| rst_n | input | 1 | Synchronous active-low reset; also samples the single-clock strap |
| rd_sel_n | input | 1 | Active-low read port select |
| wr_sel_n | input | 1 | Active-low write port select |
| addr | input | ADDR_W | Shared address bus, read address at `clk_in` rise, write address at `clk_in_n` rise |
| wdata | input | DATA_W | Write data, lower word then upper word |
| lane_we_n | input | LANES | Active-low write enable per 9-bit lane, sampled with each word |
| rdata | output | DATA_W | Read data, lower word then upper word |
| rdata_vld | output | 1 | High while a read word is driven; replaces the output enable of tri-state pins |

## Verification
The bench builds the block with DATA_W = 36 (four lanes) and DEPTH = 64. At this size every location can be written and read back in a single pass, and all 256 combinations of lower and upper lane enables are swept exhaustively against a reference array in the bench. Both half-cycle words and the valid flag are compared on every output phase. This covers same-cycle forwarding, back-to-back bursts and the release of the drive after a burst. A second reset with the strap applied, followed by inverted output clocks, makes a wrongly chosen timing source swap the two words, so it is seen at the ports.

// File: rtl/b2s_pkg.sv
package b2s_pkg;

   // width of one byte-write lane
   localparam int unsigned LANE_W = 9;

   // supported data widths of the model
   function automatic bit width_ok(int unsigned w);
      return (w == 18) || (w == 36);
   endfunction

endpackage

// File: rtl/b2s_lane_mask.sv
module b2s_lane_mask
   import b2s_pkg::*;
#(
   parameter int unsigned LANES = 4,
   localparam int unsigned BITS = LANES * LANE_W
) (
   input  logic [LANES-1:0] lane_en,
   output logic [BITS-1:0]  bit_en
);

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign bit_en[g*LANE_W +: LANE_W] = {LANE_W{lane_en[g]}};
   end

endmodule

// File: rtl/b2s_wr_capture.sv
module b2s_wr_capture #(
   parameter int unsigned DATA_W = 36,
   parameter int unsigned LANES  = 4,
   parameter int unsigned ADDR_W = 6
) (
   input  logic              clk_in,
   input  logic              clk_in_n,
   input  logic              rst_n,
   input  logic              wr_sel_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [LANES-1:0]  lane_we_n,
   output logic              pend_v,
   output logic [ADDR_W-1:0] pend_addr,
   output logic [DATA_W-1:0] pend_lo,
   output logic [DATA_W-1:0] pend_hi,
   output logic [LANES-1:0]  pend_lo_en,
   output logic [LANES-1:0]  pend_hi_en
);

   logic              armed;
   logic [DATA_W-1:0] lo_q;
   logic [LANES-1:0]  lo_en_q;

   // first half of the burst: command, lower word, lower lane enables
   always_ff @(posedge clk_in) begin
      if (!rst_n) begin
         armed   <= 1'b0;
         lo_q    <= '0;
         lo_en_q <= '0;
      end else begin
         armed   <= ~wr_sel_n;
         lo_q    <= wdata;
         lo_en_q <= ~lane_we_n;
      end
   end

   // second half: address, upper word, upper lane enables
   always_ff @(posedge clk_in_n) begin
      if (!rst_n) begin
         pend_v     <= 1'b0;
         pend_addr  <= '0;
         pend_lo    <= '0;
         pend_hi    <= '0;
         pend_lo_en <= '0;
         pend_hi_en <= '0;
      end else begin
         pend_v <= armed;
         if (armed) begin
            pend_addr  <= addr;
            pend_lo    <= lo_q;
            pend_lo_en <= lo_en_q;
            pend_hi    <= wdata;
            pend_hi_en <= ~lane_we_n;
         end
      end
   end

endmodule

// File: rtl/b2s_core_array.sv
module b2s_core_array #(
   parameter int unsigned DATA_W = 36,
   parameter int unsigned LANES  = 4,
   parameter int unsigned DEPTH  = 64,
   parameter int unsigned ADDR_W = 6
) (
   input  logic              clk_in,
   input  logic              rst_n,
   input  logic              rd_sel_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              pend_v,
   input  logic [ADDR_W-1:0] pend_addr,
   input  logic [DATA_W-1:0] pend_lo,
   input  logic [DATA_W-1:0] pend_hi,
   input  logic [LANES-1:0]  pend_lo_en,
   input  logic [LANES-1:0]  pend_hi_en,
   output logic              rd_v,
   output logic [DATA_W-1:0] rd_lo,
   output logic [DATA_W-1:0] rd_hi
);

   logic [DATA_W-1:0] mem_lo [DEPTH];
   logic [DATA_W-1:0] mem_hi [DEPTH];

   logic [DATA_W-1:0] m_lo, m_hi;
   logic [DATA_W-1:0] merge_lo, merge_hi;
   logic              rd_go;
   logic [ADDR_W-1:0] rd_addr_q;
   logic              hit;

   b2s_lane_mask #(.LANES(LANES)) u_mask_lo (.lane_en(pend_lo_en), .bit_en(m_lo));
   b2s_lane_mask #(.LANES(LANES)) u_mask_hi (.lane_en(pend_hi_en), .bit_en(m_hi));

   // new location contents once the pending burst lands
   always_comb begin
      merge_lo = (pend_lo & m_lo) | (mem_lo[pend_addr] & ~m_lo);
      merge_hi = (pend_hi & m_hi) | (mem_hi[pend_addr] & ~m_hi);
   end

   assign hit = pend_v && (pend_addr == rd_addr_q);

   // commit of a fully captured write burst
   always_ff @(posedge clk_in) begin
      if (rst_n && pend_v) begin
         mem_lo[pend_addr] <= merge_lo;
         mem_hi[pend_addr] <= merge_hi;
      end
   end

   // read command stage and fetch stage, with forwarding of the landing write
   always_ff @(posedge clk_in) begin
      if (!rst_n) begin
         rd_go     <= 1'b0;
         rd_addr_q <= '0;
         rd_v      <= 1'b0;
         rd_lo     <= '0;
         rd_hi     <= '0;
      end else begin
         rd_go     <= ~rd_sel_n;
         rd_addr_q <= addr;
         rd_v      <= rd_go;
         if (rd_go) begin
            rd_lo <= hit ? merge_lo : mem_lo[rd_addr_q];
            rd_hi <= hit ? merge_hi : mem_hi[rd_addr_q];
         end
      end
   end

endmodule

// File: rtl/b2s_ddr_out.sv
module b2s_ddr_out #(
   parameter int unsigned DATA_W = 36
) (
   input  logic              oclk,
   input  logic              oclk_n,
   input  logic              rst_n,
   input  logic              rd_v,
   input  logic [DATA_W-1:0] rd_lo,
   input  logic [DATA_W-1:0] rd_hi,
   output logic [DATA_W-1:0] rdata,
   output logic              rdata_vld
);

   logic              cap_v;
   logic [DATA_W-1:0] lo_q;
   logic [DATA_W-1:0] hi_hold;
   logic              hi_v;
   logic [DATA_W-1:0] hi_q;

   // complement output edge: present lower word, park upper word
   always_ff @(posedge oclk_n) begin
      if (!rst_n) begin
         cap_v   <= 1'b0;
         lo_q    <= '0;
         hi_hold <= '0;
      end else begin
         cap_v   <= rd_v;
         lo_q    <= rd_v ? rd_lo : '0;
         hi_hold <= rd_v ? rd_hi : '0;
      end
   end

   // true output edge: present upper word
   always_ff @(posedge oclk) begin
      if (!rst_n) begin
         hi_v <= 1'b0;
         hi_q <= '0;
      end else begin
         hi_v <= cap_v;
         hi_q <= hi_hold;
      end
   end

   // phase select: high phase carries the upper word, low phase the lower
   assign rdata     = oclk ? hi_q : lo_q;
   assign rdata_vld = oclk ? hi_v : cap_v;

endmodule

// File: rtl/b2s_sram.sv
module b2s_sram
   import b2s_pkg::*;
#(
   parameter int unsigned DATA_W = 36,
   parameter int unsigned DEPTH  = 64,
   localparam int unsigned LANES  = DATA_W / LANE_W,
   localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk_in,
   input  logic              clk_in_n,
   input  logic              clk_out,
   input  logic              clk_out_n,
   input  logic              rst_n,
   input  logic              rd_sel_n,
   input  logic              wr_sel_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [LANES-1:0]  lane_we_n,
   output logic [DATA_W-1:0] rdata,
   output logic              rdata_vld
);

   if (!width_ok(DATA_W)) begin : g_bad_width
      $error("b2s_sram: DATA_W must be 18 or 36");
   end
   if ((DEPTH < 2) || ((DEPTH & (DEPTH - 1)) != 0) || (DEPTH > 1024)) begin : g_bad_depth
      $error("b2s_sram: DEPTH must be a power of two from 2 to 1024");
   end

   logic              sc_mode;
   logic              oclk, oclk_n;
   logic              pend_v;
   logic [ADDR_W-1:0] pend_addr;
   logic [DATA_W-1:0] pend_lo, pend_hi;
   logic [LANES-1:0]  pend_lo_en, pend_hi_en;
   logic              rd_v;
   logic [DATA_W-1:0] rd_lo, rd_hi;

   // strap: output clocks both high during reset selects input-clock timing
   always_ff @(posedge clk_in) begin
      if (!rst_n) sc_mode <= clk_out & clk_out_n;
   end

   assign oclk   = sc_mode ? clk_in   : clk_out;
   assign oclk_n = sc_mode ? clk_in_n : clk_out_n;

   b2s_wr_capture #(.DATA_W(DATA_W), .LANES(LANES), .ADDR_W(ADDR_W)) u_wr (
      .clk_in     (clk_in),
      .clk_in_n   (clk_in_n),
      .rst_n      (rst_n),
      .wr_sel_n   (wr_sel_n),
      .addr       (addr),
      .wdata      (wdata),
      .lane_we_n  (lane_we_n),
      .pend_v     (pend_v),
      .pend_addr  (pend_addr),
      .pend_lo    (pend_lo),
      .pend_hi    (pend_hi),
      .pend_lo_en (pend_lo_en),
      .pend_hi_en (pend_hi_en)
   );

   b2s_core_array #(.DATA_W(DATA_W), .LANES(LANES), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_core (
      .clk_in     (clk_in),
      .rst_n      (rst_n),
      .rd_sel_n   (rd_sel_n),
      .addr       (addr),
      .pend_v     (pend_v),
      .pend_addr  (pend_addr),
      .pend_lo    (pend_lo),
      .pend_hi    (pend_hi),
      .pend_lo_en (pend_lo_en),
      .pend_hi_en (pend_hi_en),
      .rd_v       (rd_v),
      .rd_lo      (rd_lo),
      .rd_hi      (rd_hi)
   );

   b2s_ddr_out #(.DATA_W(DATA_W)) u_out (
      .oclk      (oclk),
      .oclk_n    (oclk_n),
      .rst_n     (rst_n),
      .rd_v      (rd_v),
      .rd_lo     (rd_lo),
      .rd_hi     (rd_hi),
      .rdata     (rdata),
      .rdata_vld (rdata_vld)
   );

endmodule

// File: rtl/b2s_sram_chk.sv
module b2s_sram_chk (
   input logic clk_in,
   input logic rst_n,
   input logic rd_sel_n,
   input logic wr_sel_n,
   input logic rd_v,
   input logic pend_v,
   input logic sc_mode
);

   // R1: a read command reaches the fetch stage two input-clock rises later
   a_r1_read_launch: assert property (@(posedge clk_in) disable iff (!rst_n)
      !rd_sel_n |-> ##2 rd_v);

   // R11: no read command, no fetched burst
   a_r11_read_idle: assert property (@(posedge clk_in) disable iff (!rst_n)
      rd_sel_n |-> ##2 !rd_v);

   // R2: a write command is fully captured by the next input-clock rise
   a_r2_write_pending: assert property (@(posedge clk_in) disable iff (!rst_n)
      !wr_sel_n |=> pend_v);

   // R10: reset clears both pipelines
   a_r10_reset_clear: assert property (@(posedge clk_in)
      !rst_n |=> (!rd_v && !pend_v));

   // R8: the timing-source choice never changes outside reset
   a_r8_mode_held: assert property (@(posedge clk_in) disable iff (!rst_n)
      $past(rst_n) |-> $stable(sc_mode));

endmodule

bind b2s_sram b2s_sram_chk u_chk (
   .clk_in   (clk_in),
   .rst_n    (rst_n),
   .rd_sel_n (rd_sel_n),
   .wr_sel_n (wr_sel_n),
   .rd_v     (rd_v),
   .pend_v   (pend_v),
   .sc_mode  (sc_mode)
);

// File: tb/b2s_sram_tb.sv
module b2s_sram_tb;

   localparam int DW  = 36;
   localparam int LN  = 4;
   localparam int DEP = 64;

   logic          clk_in = 1'b0;
   logic          clk_in_n;
   logic          clk_out, clk_out_n;
   logic          kd = 1'b0;
   logic          sc_strap = 1'b0;
   logic          c_inv = 1'b0;
   logic          rst_n = 1'b0;
   logic          rd_sel_n = 1'b1;
   logic          wr_sel_n = 1'b1;
   logic [5:0]    addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [LN-1:0] lane_we_n = '1;
   logic [DW-1:0] rdata;
   logic          rdata_vld;

   int tests = 0;
   int fails = 0;
   int cyc = 0;
   bit mon_on = 1'b0;

   logic [DW-1:0] mlo [DEP];
   logic [DW-1:0] mhi [DEP];
   bit            sv   [8];
   logic [DW-1:0] slo  [8];
   logic [DW-1:0] shi  [8];
   int            stag [8];

   always #10 clk_in = ~clk_in;
   assign clk_in_n = ~clk_in;
   always @(clk_in) kd <= #2 clk_in;
   assign clk_out   = sc_strap ? 1'b1 : (kd ^ c_inv);
   assign clk_out_n = sc_strap ? 1'b1 : ~(kd ^ c_inv);

   always @(posedge clk_in) cyc = cyc + 1;

   b2s_sram #(.DATA_W(DW), .DEPTH(DEP)) u_dut (
      .clk_in    (clk_in),
      .clk_in_n  (clk_in_n),
      .clk_out   (clk_out),
      .clk_out_n (clk_out_n),
      .rst_n     (rst_n),
      .rd_sel_n  (rd_sel_n),
      .wr_sel_n  (wr_sel_n),
      .addr      (addr),
      .wdata     (wdata),
      .lane_we_n (lane_we_n),
      .rdata     (rdata),
      .rdata_vld (rdata_vld)
   );

   function automatic logic [DW-1:0] pat(int a, int s);
      logic [63:0] x;
      x = (64'(a + 1) * 64'h9E3779B97F4A7C15) ^ (64'(s + 3) * 64'hC2B2AE3D27D4EB4F);
      x = x ^ (x >> 29);
      return x[DW-1:0];
   endfunction

   // R4: lane i covers bits 9*i+8 .. 9*i
   function automatic logic [DW-1:0] mrg(logic [DW-1:0] old, logic [DW-1:0] nw, logic [LN-1:0] en);
      logic [DW-1:0] r;
      r = old;
      for (int i = 0; i < LN; i++) if (en[i]) r[i*9 +: 9] = nw[i*9 +: 9];
      return r;
   endfunction

   // one clk_in period of stimulus; reference model updated write-first (R5)
   task automatic drive(input bit r, input int ra, input bit w, input int wa,
                        input logic [DW-1:0] dl, input logic [LN-1:0] el,
                        input logic [DW-1:0] dh, input logic [LN-1:0] eh, input int tag);
      int idx;
      @(negedge clk_in); #5;
      if (w) begin
         mlo[wa] = mrg(mlo[wa], dl, el);
         mhi[wa] = mrg(mhi[wa], dh, eh);
      end
      idx = (cyc + 3) % 8;
      sv[idx]   = r;
      slo[idx]  = mlo[ra];
      shi[idx]  = mhi[ra];
      stag[idx] = tag;
      rd_sel_n  = ~r;
      wr_sel_n  = ~w;
      addr      = 6'(ra);
      wdata     = dl;
      lane_we_n = ~el;
      @(posedge clk_in); #5;
      addr      = 6'(wa);
      wdata     = dh;
      lane_we_n = ~eh;
   endtask

   task automatic idle(input int tag);
      drive(1'b0, 0, 1'b0, 0, '0, '0, '0, '0, tag);
   endtask

   task automatic mon(input int idx, input bit hi);
      logic [DW-1:0] e;
      bit ev;
      ev = sv[idx];
      e  = ev ? (hi ? shi[idx] : slo[idx]) : '0;
      tests++;
      if (rdata_vld !== ev || rdata !== e) begin
         fails++;
         $display("FAIL R%0d %s word: actual vld=%0b data=%h expected vld=%0b data=%h",
                  stag[idx], hi ? "upper" : "lower", rdata_vld, rdata, ev, e);
      end
   endtask

   // lower word window (after complement output edge), upper word window (after true edge)
   always @(negedge clk_in) if (mon_on) begin #5; mon((cyc + 1) % 8, 1'b0); end
   always @(posedge clk_in) if (mon_on) begin #5; mon(cyc % 8, 1'b1); end

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
   endtask

   initial begin
      #(20 * 100000);
      fails++;
      $display("FAIL watchdog: actual=timeout expected=finished");
      summary();
      $finish;
   end

   initial begin
      for (int i = 0; i < 8; i++) begin sv[i] = 0; slo[i] = '0; shi[i] = '0; stag[i] = 6; end
      for (int i = 0; i < DEP; i++) begin mlo[i] = '0; mhi[i] = '0; end

      // R10: reset state
      repeat (4) idle(10);
      tests++;
      if (rdata_vld !== 1'b0 || rdata !== '0) begin
         fails++;
         $display("FAIL R10 reset: actual vld=%0b data=%h expected vld=0 data=0", rdata_vld, rdata);
      end
      rst_n = 1'b1;
      repeat (2) idle(10);
      mon_on = 1'b1;
      repeat (2) idle(10);

      // R2 R3: fill every location with both words
      for (int a = 0; a < DEP; a++) drive(1'b0, 0, 1'b1, a, pat(a, 0), '1, pat(a, 1), '1, 2);
      // R1 R3: back-to-back reads of every location
      for (int a = 0; a < DEP; a++) drive(1'b1, a, 1'b0, 0, '0, '0, '0, '0, 1);
      repeat (3) idle(6); // R6: release after last burst

      // R4: all lower/upper lane enable combinations
      for (int m = 0; m < 256; m++) begin
         drive(1'b0, 0, 1'b1, m % DEP, pat(m, 7), 4'(m), pat(m, 8), 4'(m >> 4), 4);
         drive(1'b1, m % DEP, 1'b0, 0, '0, '0, '0, '0, 4);
      end
      repeat (2) idle(6);

      // R5: same-edge forwarding, full and partial lanes, and write on consecutive cycles
      for (int a = 0; a < 8; a++) begin
         drive(1'b1, a, 1'b1, a, pat(a, 20), '1, pat(a, 21), '1, 5);
         drive(1'b1, a, 1'b1, a, pat(a, 22), 4'(a + 3), pat(a, 23), 4'(9 - a), 5);
         drive(1'b1, a, 1'b0, 0, '0, '0, '0, '0, 5);
      end
      repeat (2) idle(6);

      // R9: concurrent read and write to different locations
      for (int a = 0; a < 8; a++) drive(1'b1, a + 16, 1'b1, a + 40, pat(a, 30), '1, pat(a, 31), '1, 9);
      for (int a = 0; a < 8; a++) drive(1'b1, a + 40, 1'b1, a + 16, pat(a, 32), 4'hA, pat(a, 33), 4'h5, 9);
      for (int a = 0; a < 8; a++) drive(1'b1, a + 16, 1'b0, 0, '0, '0, '0, '0, 9);

      // R7: started write completes though select drops next rise; read then idle
      drive(1'b0, 0, 1'b1, 50, pat(50, 40), '1, pat(50, 41), '1, 7);
      idle(7);
      drive(1'b1, 50, 1'b0, 0, '0, '0, '0, '0, 7);
      repeat (3) idle(7);

      // R11: deselected write with live data and enables changes nothing
      @(negedge clk_in); #5;
      rd_sel_n = 1'b1; wr_sel_n = 1'b1; addr = 6'd51; wdata = '1; lane_we_n = '0;
      sv[(cyc + 3) % 8] = 0; stag[(cyc + 3) % 8] = 11;
      @(posedge clk_in); #5;
      addr = 6'd51; wdata = '1; lane_we_n = '0;
      idle(11);
      drive(1'b1, 51, 1'b0, 0, '0, '0, '0, '0, 11);
      repeat (3) idle(11);

      // R8: strap applied during reset, then output clocks inverted afterwards
      repeat (3) idle(6);
      mon_on = 1'b0;
      rst_n = 1'b0;
      sc_strap = 1'b1;
      repeat (4) idle(8);
      rst_n = 1'b1;
      repeat (2) idle(8);
      sc_strap = 1'b0;
      c_inv = 1'b1;
      repeat (2) idle(8);
      mon_on = 1'b1;
      for (int a = 0; a < 8; a++) drive(1'b1, a, 1'b1, a + 8, pat(a, 50), '1, pat(a, 51), '1, 8);
      for (int a = 0; a < 8; a++) drive(1'b1, a + 8, 1'b0, 0, '0, '0, '0, '0, 8);
      repeat (3) idle(8);
      mon_on = 1'b0;

      summary();
      $finish;
   end

endmodule